// File: doc/BRIEF.md
# Trap Vector Selector and Handler Address Generator

This block sits at the point where a processor core commits to taking a trap. From the current trap depth, the two depth limits, the mode bits of the running thread, the trap type and the two handler base registers, it picks one of four destination classes and computes the handler fetch addresses. The four classes are recovery, hypervisor, supervisor and error. It also returns the trap type that the handler table is indexed with, which is not always the incoming one.

The selection is combinational. One output register stage holds the result, and `out_valid` pulses one clock after `trap_req`. Between requests the outputs keep the last result, so the fetch unit can sample them late. The error class only raises a flag. Sequencing into the error state belongs to the surrounding core.

Top module: `trap_vector_gen`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `out_valid`, `out_error`, `out_class`, `out_pc`, `out_npc`, `out_nnpc` and `out_tt` are all zero.
- R2: When `recov_mode` is 1, or `trap_lvl + 1 == max_tl`, the class is recovery (`out_class` = 0). `out_tt` is 5 and `out_pc` = `RECOV_BASE` (default 0xFF_F000_0000) ORed with bits [7:0] of (5 << 5), which is 0xA0.
- R3: When R2 does not apply and `trap_lvl == max_tl`, the class is error (`out_class` = 3). `out_error` is 1, `out_pc`, `out_npc` and `out_nnpc` are 0, and `out_tt` is the incoming type.
- R4: When R2 and R3 do not apply, `trap_lvl > max_ptl` and the target mode is supervisor, the class is hypervisor (`out_class` = 1) with `out_tt` = 2. The PC is built as in R5 with type 2.
- R5: Otherwise, the class is hypervisor when the target mode is hypervisor, or when it is supervisor and `trap_type` >= 384. The PC is `hyp_base` with bits [13:0] cleared, ORed with bits [13:0] of (`trap_type` << 5).
- R6: All other traps are class supervisor (`out_class` = 2). The PC is `sup_base` with bits [14:0] cleared, with bit 14 set when `trap_lvl + 1 > 1`, ORed with bits [13:0] of (`trap_type` << 5).
- R7: For every class except error, `out_npc` = `out_pc` + 4 and `out_nnpc` = `out_pc` + 8.
- R8: `out_valid` is 1 exactly one cycle after a cycle with `trap_req` high. Cycles without a request leave every other output unchanged.
- R9: The current mode is hypervisor when `hyp_mode` is 1, whatever `priv_mode` is. Otherwise it is supervisor when `priv_mode` is 1, and user otherwise. The target mode equals the current mode, except that user becomes supervisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | A trap is being taken this cycle |
| trap_lvl | input | TL_W | Current trap depth |
| max_tl | input | TL_W | Highest trap depth |
| max_ptl | input | TL_W | Highest depth allowed for supervisor traps |
| recov_mode | input | 1 | Thread is already in recovery mode |
| hyp_mode | input | 1 | Thread runs in hypervisor mode |
| priv_mode | input | 1 | Thread runs in supervisor mode |
| trap_type | input | TT_W | Type of the pending trap |
| sup_base | input | ADDR_W | Supervisor handler table base |
| hyp_base | input | ADDR_W | Hypervisor handler table base |
| out_valid | output | 1 | Result pulse, one cycle after request |
| out_error | output | 1 | Depth overflow, error state required |
| out_class | output | 2 | 0 recovery, 1 hypervisor, 2 supervisor, 3 error |
| out_pc | output | ADDR_W | Handler PC |
| out_npc | output | ADDR_W | Handler PC + 4 |
| out_nnpc | output | ADDR_W | Handler PC + 8 |
| out_tt | output | TT_W | Trap type used for the vector |

## Verification
On every cycle, the assertions check the request-to-valid timing and the holding of outputs between requests. They also check the +4/+8 spacing of the fetch addresses, the fixed type in the recovery class, and the zeroed addresses tied to the error flag. The priority order of the class decision can only be shown by the bench scenarios. These include the forced watchdog redirect over a hypervisor-bound type, the precedence of hypervisor mode over supervisor mode, the 383/384 type boundary and the depth-dependent bit 14 of the supervisor address. The bench's behavioural model compares every output on every clock.

// File: rtl/trap_vec_pkg.sv
package trap_vec_pkg;
  typedef enum logic [1:0] {
    VC_RECOV = 2'd0,
    VC_HYP   = 2'd1,
    VC_SUP   = 2'd2,
    VC_ERR   = 2'd3
  } vec_class_e;

  typedef enum logic [1:0] {
    LV_USER = 2'd0,
    LV_SUP  = 2'd1,
    LV_HYP  = 2'd2
  } priv_lvl_e;

  localparam int RECOV_TT     = 5;
  localparam int WDOG_TT      = 2;
  localparam int HYP_TT_FLOOR = 384;
  localparam int INSN_BYTES   = 4;
endpackage

// File: rtl/tv_level_decode.sv
module tv_level_decode
  import trap_vec_pkg::*;
(
  input  logic      hyp_mode,
  input  logic      priv_mode,
  output priv_lvl_e cur_lvl,
  output priv_lvl_e tgt_lvl
);
  always_comb begin
    if (hyp_mode)       cur_lvl = LV_HYP;
    else if (priv_mode) cur_lvl = LV_SUP;
    else                cur_lvl = LV_USER;
  end

  // user traps land in supervisor mode; other modes stay where they are
  always_comb begin
    if (cur_lvl == LV_USER) tgt_lvl = LV_SUP;
    else                    tgt_lvl = cur_lvl;
  end
endmodule

// File: rtl/tv_class_select.sv
module tv_class_select
  import trap_vec_pkg::*;
#(
  parameter int TL_W = 3,
  parameter int TT_W = 9
) (
  input  logic [TL_W-1:0] trap_lvl,
  input  logic [TL_W-1:0] max_tl,
  input  logic [TL_W-1:0] max_ptl,
  input  logic            recov_mode,
  input  priv_lvl_e       tgt_lvl,
  input  logic [TT_W-1:0] trap_type,
  output vec_class_e      vclass,
  output logic [TT_W-1:0] vec_tt,
  output logic            deep_nest
);
  localparam int XW = TL_W + 1;

  logic [XW-1:0] next_lvl;
  logic          at_last_minus1;
  logic          at_last;
  logic          over_sup;
  logic          high_type;

  assign next_lvl       = {1'b0, trap_lvl} + XW'(1);
  assign at_last_minus1 = (next_lvl == {1'b0, max_tl});
  assign at_last        = (trap_lvl == max_tl);
  assign over_sup       = (trap_lvl > max_ptl);
  assign high_type      = (int'(trap_type) >= HYP_TT_FLOOR);
  assign deep_nest      = (next_lvl > XW'(1));

  // ordered priority: recovery, error, watchdog redirect, hypervisor, supervisor
  always_comb begin
    vclass = VC_SUP;
    vec_tt = trap_type;
    if (recov_mode || at_last_minus1) begin
      vclass = VC_RECOV;
      vec_tt = TT_W'(RECOV_TT);
    end else if (at_last) begin
      vclass = VC_ERR;
    end else if (over_sup && tgt_lvl == LV_SUP) begin
      vclass = VC_HYP;
      vec_tt = TT_W'(WDOG_TT);
    end else if (tgt_lvl == LV_HYP || (tgt_lvl == LV_SUP && high_type)) begin
      vclass = VC_HYP;
    end
  end
endmodule

// File: rtl/tv_addr_gen.sv
module tv_addr_gen
  import trap_vec_pkg::*;
#(
  parameter int              ADDR_W     = 64,
  parameter int              TT_W       = 9,
  parameter logic [ADDR_W-1:0] RECOV_BASE = 64'h0000_00FF_F000_0000
) (
  input  vec_class_e        vclass,
  input  logic [TT_W-1:0]   vec_tt,
  input  logic              deep_nest,
  input  logic [ADDR_W-1:0] sup_base,
  input  logic [ADDR_W-1:0] hyp_base,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] npc,
  output logic [ADDR_W-1:0] nnpc
);
  localparam int OFF_W = TT_W + 5;
  localparam logic [ADDR_W-1:0] M8  = ADDR_W'(64'hFF);
  localparam logic [ADDR_W-1:0] M14 = ADDR_W'(64'h3FFF);
  localparam logic [ADDR_W-1:0] M15 = ADDR_W'(64'h7FFF);
  localparam logic [ADDR_W-1:0] B14 = ADDR_W'(64'h4000);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] pc_recov;
  logic [ADDR_W-1:0] pc_hyp;
  logic [ADDR_W-1:0] pc_sup;

  assign off      = ADDR_W'({vec_tt, 5'b0_0000});
  assign pc_recov = RECOV_BASE | (off & M8);
  assign pc_hyp   = (hyp_base & ~M14) | (off & M14);
  assign pc_sup   = (sup_base & ~M15) | (deep_nest ? B14 : '0) | (off & M14);

  always_comb begin
    unique case (vclass)
      VC_RECOV: pc = pc_recov;
      VC_HYP:   pc = pc_hyp;
      VC_SUP:   pc = pc_sup;
      default:  pc = '0;
    endcase
  end

  assign npc  = (vclass == VC_ERR) ? '0 : pc + STEP;
  assign nnpc = (vclass == VC_ERR) ? '0 : pc + STEP + STEP;

  logic unused_w;
  assign unused_w = ^off[ADDR_W-1:0] & 1'b0;
  initial assert (OFF_W <= ADDR_W);
endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
  import trap_vec_pkg::*;
#(
  parameter int                ADDR_W     = 64,
  parameter int                TL_W       = 3,
  parameter int                TT_W       = 9,
  parameter logic [ADDR_W-1:0] RECOV_BASE = 64'h0000_00FF_F000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trap_req,
  input  logic [TL_W-1:0]   trap_lvl,
  input  logic [TL_W-1:0]   max_tl,
  input  logic [TL_W-1:0]   max_ptl,
  input  logic              recov_mode,
  input  logic              hyp_mode,
  input  logic              priv_mode,
  input  logic [TT_W-1:0]   trap_type,
  input  logic [ADDR_W-1:0] sup_base,
  input  logic [ADDR_W-1:0] hyp_base,
  output logic              out_valid,
  output logic              out_error,
  output logic [1:0]        out_class,
  output logic [ADDR_W-1:0] out_pc,
  output logic [ADDR_W-1:0] out_npc,
  output logic [ADDR_W-1:0] out_nnpc,
  output logic [TT_W-1:0]   out_tt
);
  priv_lvl_e         cur_lvl, tgt_lvl;
  vec_class_e        vclass;
  logic [TT_W-1:0]   vec_tt;
  logic              deep_nest;
  logic [ADDR_W-1:0] pc_c, npc_c, nnpc_c;

  tv_level_decode u_lvl (
    .hyp_mode (hyp_mode),
    .priv_mode(priv_mode),
    .cur_lvl  (cur_lvl),
    .tgt_lvl  (tgt_lvl)
  );

  tv_class_select #(.TL_W(TL_W), .TT_W(TT_W)) u_sel (
    .trap_lvl  (trap_lvl),
    .max_tl    (max_tl),
    .max_ptl   (max_ptl),
    .recov_mode(recov_mode),
    .tgt_lvl   (tgt_lvl),
    .trap_type (trap_type),
    .vclass    (vclass),
    .vec_tt    (vec_tt),
    .deep_nest (deep_nest)
  );

  tv_addr_gen #(.ADDR_W(ADDR_W), .TT_W(TT_W), .RECOV_BASE(RECOV_BASE)) u_addr (
    .vclass   (vclass),
    .vec_tt   (vec_tt),
    .deep_nest(deep_nest),
    .sup_base (sup_base),
    .hyp_base (hyp_base),
    .pc       (pc_c),
    .npc      (npc_c),
    .nnpc     (nnpc_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_error <= 1'b0;
      out_class <= '0;
      out_pc    <= '0;
      out_npc   <= '0;
      out_nnpc  <= '0;
      out_tt    <= '0;
    end else begin
      out_valid <= trap_req;
      if (trap_req) begin
        out_error <= (vclass == VC_ERR);
        out_class <= vclass;
        out_pc    <= pc_c;
        out_npc   <= npc_c;
        out_nnpc  <= nnpc_c;
        out_tt    <= vec_tt;
      end
    end
  end

  logic cur_unused;
  assign cur_unused = ^cur_lvl;

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    trap_req |=> out_valid);
  assert_valid_drops_R8: assert property (@(posedge clk) disable iff (rst)
    !trap_req |=> !out_valid);
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !trap_req |=> ($stable(out_pc) && $stable(out_class) && $stable(out_tt)));
  assert_step_addr_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class != VC_ERR) |->
      (out_npc == out_pc + ADDR_W'(4) && out_nnpc == out_pc + ADDR_W'(8)));
  assert_recov_type_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == VC_RECOV) |-> out_tt == TT_W'(RECOV_TT));
  assert_error_flag_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_error == (out_class == VC_ERR)) &&
                  (!out_error || out_pc == '0));
endmodule

// File: tb/trap_vector_gen_bench.sv
module trap_vector_gen_bench;
  localparam int AW = 64;
  localparam int TLW = 3;
  localparam int TTW = 9;

  logic clk = 0;
  logic rst = 1;
  logic trap_req = 0;
  logic [TLW-1:0] trap_lvl = 0, max_tl = 6, max_ptl = 2;
  logic recov_mode = 0, hyp_mode = 0, priv_mode = 0;
  logic [TTW-1:0] trap_type = 0;
  logic [AW-1:0] sup_base = 64'h0000_1234_5678_9ABC;
  logic [AW-1:0] hyp_base = 64'h0000_0ABC_DEF0_1357;
  logic out_valid, out_error;
  logic [1:0] out_class;
  logic [AW-1:0] out_pc, out_npc, out_nnpc;
  logic [TTW-1:0] out_tt;

  always #5 clk = ~clk;

  trap_vector_gen u_trap_vector_gen (
    .clk(clk), .rst(rst), .trap_req(trap_req), .trap_lvl(trap_lvl),
    .max_tl(max_tl), .max_ptl(max_ptl), .recov_mode(recov_mode),
    .hyp_mode(hyp_mode), .priv_mode(priv_mode), .trap_type(trap_type),
    .sup_base(sup_base), .hyp_base(hyp_base), .out_valid(out_valid),
    .out_error(out_error), .out_class(out_class), .out_pc(out_pc),
    .out_npc(out_npc), .out_nnpc(out_nnpc), .out_tt(out_tt)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // expected state, updated behaviourally at each rising edge
  logic e_valid = 0, e_err = 0;
  int   e_class = 0;
  longint unsigned e_pc = 0, e_npc = 0, e_nnpc = 0;
  int   e_tt = 0;
  string e_tag = "R1";

  task automatic chk(string req, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      e_valid = 0; e_err = 0; e_class = 0; e_pc = 0; e_npc = 0; e_nnpc = 0; e_tt = 0;
      e_tag = "R1";
    end else begin
      e_valid = trap_req;
      if (trap_req) begin
        int lvl, tgt, t, tl, mt, mp;
        longint unsigned off;
        bit b14;
        tl = trap_lvl; mt = max_tl; mp = max_ptl; t = trap_type;
        lvl = hyp_mode ? 2 : (priv_mode ? 1 : 0); // R9 mode order
        tgt = (lvl == 0) ? 1 : lvl;
        b14 = (tl + 1) > 1;
        if (recov_mode || tl + 1 == mt) begin
          e_class = 0; e_tt = 5; e_tag = "R2";
        end else if (tl == mt) begin
          e_class = 3; e_tt = t; e_tag = "R3";
        end else if (tl > mp && tgt == 1) begin
          e_class = 1; e_tt = 2; e_tag = "R4";
        end else if (tgt == 2 || (tgt == 1 && t >= 384)) begin
          e_class = 1; e_tt = t; e_tag = "R5";
        end else begin
          e_class = 2; e_tt = t; e_tag = "R6";
        end
        off = longint'(e_tt) * 32;
        case (e_class)
          0: e_pc = 64'hFF_F000_0000 | (off % 256);
          1: e_pc = (hyp_base - (hyp_base % 16384)) + (off % 16384);
          2: e_pc = (sup_base - (sup_base % 32768)) + (b14 ? 16384 : 0) + (off % 16384);
          default: e_pc = 0;
        endcase
        e_err  = (e_class == 3);
        e_npc  = e_err ? 0 : e_pc + 4;
        e_nnpc = e_err ? 0 : e_pc + 8;
      end
    end
  end

  always @(negedge clk) begin
    if (cycles > 0) begin
      chk(e_valid || rst ? e_tag : "R8", "valid", out_valid, e_valid);
      chk(e_tag, "class", out_class, e_class);
      chk(e_tag, "pc", out_pc, e_pc);
      chk(e_tag, "tt", out_tt, e_tt);
      chk(e_tag, "error", out_error, e_err);
      chk((e_class == 3) ? "R3" : "R7", "npc", out_npc, e_npc);
      chk((e_class == 3) ? "R3" : "R7", "nnpc", out_nnpc, e_nnpc);
    end
  end

  task automatic trap(int tl, bit rv, bit hy, bit pv, int tt);
    trap_req = 1; trap_lvl = TLW'(tl); recov_mode = rv; hyp_mode = hy;
    priv_mode = pv; trap_type = TTW'(tt);
    @(negedge clk);
    trap_req = 0;
    @(negedge clk); // idle cycle: outputs must hold (R8)
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;                  // R1 reset values checked above
    trap(1, 1, 0, 1, 'h30);   // R2 recovery mode set
    trap(5, 0, 0, 0, 'h41);   // R2 depth == max-1
    trap(6, 0, 1, 0, 'h41);   // R3 depth == max
    trap(3, 0, 0, 0, 'h24);   // R4 user over supervisor limit
    trap(3, 0, 0, 1, 'h1F0);  // R4 redirect beats high type
    trap(1, 0, 1, 1, 'h24);   // R5 and R9: hypervisor wins over supervisor bit
    trap(1, 0, 0, 1, 384);    // R5 boundary type
    trap(1, 0, 0, 1, 383);    // R6 just below boundary, bit 14 set
    trap(0, 0, 0, 0, 'h24);   // R6 depth 0, bit 14 clear
    trap(2, 0, 0, 1, 'h10);   // R6
    for (int i = 0; i < 400; i++) begin
      trap_req   = $urandom_range(0, 1);
      trap_lvl   = TLW'($urandom_range(0, 7));
      recov_mode = ($urandom_range(0, 7) == 0);
      hyp_mode   = $urandom_range(0, 1);
      priv_mode  = $urandom_range(0, 1);
      trap_type  = TTW'($urandom_range(0, 511));
      if (i % 50 == 0) begin
        sup_base = {$urandom, $urandom};
        hyp_base = {$urandom, $urandom};
      end
      @(negedge clk);
    end
    trap_req = 0;
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog R8 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule